// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master of a two-wire synchronous link. It generates the shift clock from a programmable divider. It samples the data line on each falling edge of that clock, least-significant bit first, and assembles eight-bit words. In nine-bit mode it adds a ninth bit that stays attached to its word.

A host starts reception in one of two ways. A one-shot request collects a single word and then withdraws itself. A level-held continuous enable keeps collecting words until it is dropped, and it takes precedence over the one-shot request. Finished words enter a two-entry receive queue. The host sees the oldest entry as a data word plus a status word that holds the ninth bit and an overrun flag. A read pulse retires that entry. A ready flag and a maskable interrupt tell the host that words are waiting.

When a word completes and the queue has no room, the overrun flag is set and the word is lost. While the flag is set, nothing enters the queue. The flag clears only when the continuous enable goes from high to low.

Top module: `srx_sync_master`

## Requirements
- R1: While reception is active, `sclk_out` has a period of 4×(`div_val`+1) system clocks, and it rises half a period before it falls. When neither enable is in force it is held low.
- R2: The data line is sampled once per falling edge of `sclk_out`. Bit 0 of the word is sampled first, and an eight-bit word appears on `data_out` with its first sampled bit in position 0.
- R3: A pulse on `single_req` sets `single_busy`. Exactly one word is then received, after which `single_busy` returns to 0 by itself and `sclk_out` stays low.
- R4: While `cont_en` is 1, words are received back to back. Dropping `cont_en` abandons a partial word. When both enables are in force, the continuous one governs and `single_busy` stays 1 until a word completes with `cont_en` at 0.
- R5: The receive queue holds two words and returns them oldest first on `data_out`/`bit9_out`. A `rd_pulse` retires the oldest entry.
- R6: `rx_ready` is 1 exactly when the queue holds at least one word. It drops after the read that empties the queue. A `rd_pulse` while the queue is empty changes nothing.
- R7: `irq` equals `rx_ready` when `irq_en` is 1 and is 0 otherwise.
- R8: If a word completes while the queue holds two words, `ovr_flag` is set and that word is discarded.
- R9: While `ovr_flag` is 1, no word enters the queue, even after reads make room. `ovr_flag` is cleared only by a 1→0 transition of `cont_en`.
- R10: With `nine_bit` at 1, each word is nine bits long. The last sampled bit is shown on `bit9_out` alongside its own eight data bits. With `nine_bit` at 0, `bit9_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_val | input | DIVW | Shift clock divider setting |
| nine_bit | input | 1 | Selects nine-bit words |
| single_req | input | 1 | One-cycle pulse requesting a single word |
| cont_en | input | 1 | Continuous reception enable (level) |
| irq_en | input | 1 | Interrupt enable |
| rd_pulse | input | 1 | Retires the oldest queue entry |
| sd_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| data_out | output | 8 | Oldest queued data word |
| bit9_out | output | 1 | Ninth bit of the oldest queued word |
| ovr_flag | output | 1 | Overrun status |
| rx_ready | output | 1 | Queue holds at least one word |
| irq | output | 1 | Gated receive interrupt |
| single_busy | output | 1 | One-shot request still pending |

## Verification
The bench fills the queue and then lets a third word finish. A design that overwrote an entry or kept loading would return the wrong second word or leave `ovr_flag` low. It then frees one slot and shifts a fourth word in. A design that loads whenever there is room would show `rx_ready` still high after the second read. Another run holds both enables together, which catches a one-shot request that withdraws itself early under continuous mode. Two nine-bit words of opposite ninth-bit value are read back in order, which exposes a ninth bit that is not queued with its own word.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  localparam int SRX_DATA_W = 8;

  typedef struct packed {
    logic                  ninth;
    logic [SRX_DATA_W-1:0] data;
  } srx_entry_t;
endpackage

// File: rtl/srx_clkgen.sv
`timescale 1ns/1ps
module srx_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [DIVW-1:0] div_val,
  output logic            sclk,
  output logic            fall
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          sclk_q, sclk_n;
  logic [CW-1:0] term;
  logic          tick;

  // half period is 2*(div+1) cycles, so the terminal count is 2*div+1
  assign term = {div_val, 1'b1};
  assign tick = active && (cnt_q == term);

  always_comb begin
    cnt_n  = cnt_q;
    sclk_n = sclk_q;
    if (!active) begin
      cnt_n  = '0;
      sclk_n = 1'b0;
    end else if (tick) begin
      cnt_n  = '0;
      sclk_n = ~sclk_q;
    end else begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      sclk_q <= sclk_n;
    end
  end

  assign sclk = sclk_q;
  assign fall = tick && sclk_q;
endmodule

// File: rtl/srx_shifter.sv
`timescale 1ns/1ps
module srx_shifter
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       fall,
  input  logic       nine_bit,
  input  logic       sd_in,
  output logic       done,
  output srx_entry_t word
);
  localparam int SW = SRX_DATA_W + 1;
  localparam int BW = $clog2(SW + 1);

  logic [SW-1:0] sr_q, sr_n, sr_shift;
  logic [BW-1:0] bcnt_q, bcnt_n;
  logic [BW-1:0] last_idx;

  assign last_idx = nine_bit ? BW'(SRX_DATA_W) : BW'(SRX_DATA_W - 1);
  assign sr_shift = {sd_in, sr_q[SW-1:1]};
  assign done     = active && fall && (bcnt_q == last_idx);

  always_comb begin
    sr_n   = sr_q;
    bcnt_n = bcnt_q;
    if (!active) begin
      bcnt_n = '0;
    end else if (fall) begin
      sr_n   = sr_shift;
      bcnt_n = done ? '0 : bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else begin
      sr_q   <= sr_n;
      bcnt_q <= bcnt_n;
    end
  end

  always_comb begin
    if (nine_bit) begin
      word.ninth = sr_shift[SW-1];
      word.data  = sr_shift[SRX_DATA_W-1:0];
    end else begin
      word.ninth = 1'b0;
      word.data  = sr_shift[SW-1:1];
    end
  end

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall) |=> $stable(bcnt_q)); // R2
endmodule

// File: rtl/srx_fifo.sv
`timescale 1ns/1ps
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  srx_entry_t din,
  input  logic       pop,
  output srx_entry_t dout,
  output logic       room,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  srx_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          empty, full, pop_ok, push_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign room    = !full || pop_ok;
  assign push_ok = push && room;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push_ok ? wrap_inc(wp_q) : wp_q;
    rp_n  = pop_ok  ? wrap_inc(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (push_ok && (wp_q == AW'(g)))
        mem_q[g] <= din;
    end
  end

  assign dout  = mem_q[rp_q];
  assign count = cnt_q;

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/srx_sync_master.sv
`timescale 1ns/1ps
module srx_sync_master
  import srx_pkg::*;
#(
  parameter int DIVW  = 8,
  parameter int DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIVW-1:0]       div_val,
  input  logic                  nine_bit,
  input  logic                  single_req,
  input  logic                  cont_en,
  input  logic                  irq_en,
  input  logic                  rd_pulse,
  input  logic                  sd_in,
  output logic                  sclk_out,
  output logic [SRX_DATA_W-1:0] data_out,
  output logic                  bit9_out,
  output logic                  ovr_flag,
  output logic                  rx_ready,
  output logic                  irq,
  output logic                  single_busy
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          single_q, single_n;
  logic          ovr_q, ovr_n;
  logic          cont_q;
  logic          active, fall, word_done, room, load;
  logic          cont_drop;
  srx_entry_t    rx_word, head;
  logic [CW-1:0] fifo_cnt;

  assign active    = cont_en || single_q;
  assign cont_drop = cont_q && !cont_en;
  assign load      = word_done && !ovr_q && room;

  srx_clkgen #(.DIVW(DIVW)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .div_val (div_val),
    .sclk    (sclk_out),
    .fall    (fall)
  );

  srx_shifter u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .fall     (fall),
    .nine_bit (nine_bit),
    .sd_in    (sd_in),
    .done     (word_done),
    .word     (rx_word)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (load),
    .din   (rx_word),
    .pop   (rd_pulse),
    .dout  (head),
    .room  (room),
    .count (fifo_cnt)
  );

  always_comb begin
    single_n = single_q;
    if (word_done && !cont_en) single_n = 1'b0;
    if (single_req)            single_n = 1'b1;
    ovr_n = ovr_q;
    if (cont_drop)             ovr_n = 1'b0;
    if (word_done && !room)    ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      ovr_q    <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      single_q <= single_n;
      ovr_q    <= ovr_n;
      cont_q   <= cont_en;
    end
  end

  assign data_out    = head.data;
  assign bit9_out    = head.ninth;
  assign ovr_flag    = ovr_q;
  assign rx_ready    = (fifo_cnt != '0);
  assign irq         = rx_ready && irq_en;
  assign single_busy = single_q;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !single_q && !single_req) |=> !sclk_out); // R1
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cont_en && !single_req) |=> !single_busy); // R3
  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(word_done)); // R6
  AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> (fifo_cnt <= $past(fifo_cnt))); // R9
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && cont_en) |=> ovr_q); // R9
endmodule

// File: tb/sim_srx_sync_master.sv
`timescale 1ns/1ps
module sim_srx_sync_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_val = 8'd3;
  logic       nine_bit = 1'b0;
  logic       single_req = 1'b0;
  logic       cont_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_pulse = 1'b0;
  logic       sd_in = 1'b0;
  logic       sclk_out, bit9_out, ovr_flag, rx_ready, irq, single_busy;
  logic [7:0] data_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  srx_sync_master u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .nine_bit(nine_bit),
    .single_req(single_req), .cont_en(cont_en), .irq_en(irq_en),
    .rd_pulse(rd_pulse), .sd_in(sd_in), .sclk_out(sclk_out),
    .data_out(data_out), .bit9_out(bit9_out), .ovr_flag(ovr_flag),
    .rx_ready(rx_ready), .irq(irq), .single_busy(single_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: shifts one word out LSB first, records expectation
  task automatic send_word(input logic [8:0] val, input int nbits, input bit expect_load);
    for (int i = 0; i < nbits; i++) begin
      @(posedge sclk_out);
      #1 sd_in = val[i];
      @(negedge sclk_out);
    end
    #1;
    if (expect_load) exp_q.push_back((nbits == 9) ? val : {1'b0, val[7:0]});
  endtask

  // monitor side: compare head against scoreboard, then retire it
  task automatic read_check(input string req);
    logic [8:0] exp;
    exp = exp_q.pop_front();
    chk({bit9_out, data_out} == exp, req, {bit9_out, data_out}, exp);
    @(negedge clk) rd_pulse = 1'b1;
    @(negedge clk) rd_pulse = 1'b0;
  endtask

  task automatic pulse_single();
    @(negedge clk) single_req = 1'b1;
    @(negedge clk) single_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!sclk_out, "R1 reset sclk", sclk_out, 0);
    chk(!rx_ready, "R6 reset ready", rx_ready, 0);
    chk(!ovr_flag, "R8 reset ovr", ovr_flag, 0);
    chk(!single_busy, "R3 reset busy", single_busy, 0);

    // R1: period 4*(3+1)=16 cycles; partial word is abandoned (R4)
    cont_en = 1'b1;
    @(posedge sclk_out); t0 = cyc;
    @(posedge sclk_out);
    chk((cyc - t0) == 16, "R1 period", cyc - t0, 16);
    @(negedge clk) cont_en = 1'b0;
    repeat (40) @(negedge clk);
    chk(!sclk_out, "R1 idle low", sclk_out, 0);
    chk(!rx_ready, "R4 partial word dropped", rx_ready, 0);

    // R3/R2 single word, eight-bit
    pulse_single();
    chk(single_busy, "R3 busy set", single_busy, 1);
    send_word(9'h0A5, 8, 1'b1);
    @(negedge clk);
    chk(!single_busy, "R3 self clear", single_busy, 0);
    chk(rx_ready, "R6 ready set", rx_ready, 1);
    chk(!irq, "R7 irq masked", irq, 0);
    irq_en = 1'b1;
    #1 chk(irq, "R7 irq enabled", irq, 1);
    repeat (40) @(negedge clk);
    chk(!sclk_out, "R3 clock stops", sclk_out, 0);
    chk(!bit9_out, "R10 ninth zero in 8-bit", bit9_out, 0);
    read_check("R2 lsb first");
    chk(!rx_ready, "R6 ready cleared", rx_ready, 0);
    chk(!irq, "R7 irq follows ready", irq, 0);
    @(negedge clk) rd_pulse = 1'b1;
    @(negedge clk) rd_pulse = 1'b0;
    chk(!rx_ready && !ovr_flag, "R6 empty read ignored", rx_ready, 0);

    // R10/R4/R5 continuous nine-bit, two words
    nine_bit = 1'b1;
    cont_en = 1'b1;
    send_word(9'h13C, 9, 1'b1);
    send_word(9'h0C3, 9, 1'b1);
    cont_en = 1'b0;
    repeat (4) @(negedge clk);
    read_check("R10 ninth bit one");
    chk(rx_ready, "R5 second entry held", rx_ready, 1);
    read_check("R10 ninth bit zero");
    chk(!rx_ready, "R5 drained", rx_ready, 0);

    // R8/R9 overrun
    nine_bit = 1'b0;
    cont_en = 1'b1;
    send_word(9'h011, 8, 1'b1);
    send_word(9'h022, 8, 1'b1);
    send_word(9'h033, 8, 1'b0);
    @(negedge clk);
    chk(ovr_flag, "R8 overrun set", ovr_flag, 1);
    read_check("R8 first kept");
    chk(rx_ready, "R9 one entry left", rx_ready, 1);
    send_word(9'h044, 8, 1'b0);
    @(negedge clk);
    chk(ovr_flag, "R9 overrun persists", ovr_flag, 1);
    read_check("R8 second kept");
    chk(!rx_ready, "R9 no load while overrun", rx_ready, 0);
    @(negedge clk) cont_en = 1'b0;
    @(negedge clk);
    chk(!ovr_flag, "R9 cleared by cont drop", ovr_flag, 0);
    repeat (40) @(negedge clk);

    // R4 both enables: continuous wins, single remains pending
    cont_en = 1'b1;
    pulse_single();
    send_word(9'h05A, 8, 1'b1);
    chk(single_busy, "R4 single held under cont", single_busy, 1);
    cont_en = 1'b0;
    send_word(9'h096, 8, 1'b1);
    @(negedge clk);
    chk(!single_busy, "R4 single consumed after cont", single_busy, 0);
    read_check("R4 word under cont");
    read_check("R4 word under single");
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end
endmodule